// File: doc/BRIEF.md
# I2S Audio Serial Transmitter with Selectable Framing

This block is a master-mode audio serial transmitter. It accepts stereo sample pairs, one 16-bit left word and one 16-bit right word per transfer, through a valid/ready port into a small holding buffer. It generates four outputs from the system clock: a codec master clock, a bit clock, a word-select line and a serial data line. A frame is 32 bit-clock periods long and carries 16 slots per channel.

Three runtime controls set the frame. The first picks standard I2S framing (data delayed by one bit) or left-justified framing. The second picks 8 or 16 data bits per channel. The third picks a master clock of 256 or 384 times the sample rate. A prescale value P sets the master-clock period to 2·P system clocks, so the sample rate is clk / (2·P·256) or clk / (2·P·384).

A global enable starts and stops the whole interface. A transmit-idle control keeps the clocks running but sends silence and takes nothing from the buffer. A data request tells the source when the buffer has room. If the buffer is empty at a frame boundary, the block sends a silent frame and raises a sticky underrun flag.

Top module: `i2s_tx`

## Requirements
- R1: While rstN is low or enable is low, ws is 1, and bclk, mclk, sd and underrun are 0. dataReq is 0, and the clocks do not toggle.
- R2: While enabled, mclk is a square wave with a period of 2·P clocks, where P is the latched prescale value. A prescale of 0 acts as 1.
- R3: While enabled, one frame, measured from a falling edge of ws to the next, lasts 2·P·256 clocks when ratio384=0 and 2·P·384 clocks when ratio384=1. It contains 32 bclk periods.
- R4: ws is low for bit slots 0..15 (left channel) and high for slots 16..31 (right channel). ws and sd change only at a falling edge of bclk.
- R5: With leftJust=0 and width8=0, bit 15 of a channel's sample is sent in the slot after that channel's ws edge, followed by bits 14..0 in order. Slot 0 of a frame carries bit 0 of the previous frame's right sample, or 0 if that frame was silent.
- R6: With leftJust=1, bit 15 of a channel's sample is sent in the first slot of that channel's half frame, with no delay.
- R7: With width8=1, only sample bits 15..8 are sent, in the first 8 data slots of each channel. Every other slot is 0. In I2S framing, slot 0 is also 0.
- R8: The buffer holds DEPTH pairs (default 2). inReady is 1 exactly when the buffer has room, and a pair is accepted on a clock where inValid and inReady are both 1. dataReq is 1 when the buffer has room, enable is 1 and txIdle is 0. Exactly one pair leaves the buffer at each frame start.
- R9: If the buffer is empty at a frame start while the block is active, the whole frame is sent as zeros and underrun goes to 1. underrun stays at 1 until enable goes low.
- R10: While txIdle is 1 at a frame start, that frame is sent as zeros, no pair is taken, underrun is not set and dataReq is 0. The clocks keep running.
- R11: The framing, width, ratio and prescale inputs are latched only at a frame start, or continuously while disabled. A change made during a frame first affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global interface enable |
| txIdle | input | 1 | Send silence and take no data, with clocks running |
| leftJust | input | 1 | 1 selects left-justified framing, 0 selects I2S framing |
| width8 | input | 1 | 1 selects 8 data bits per channel, 0 selects 16 |
| ratio384 | input | 1 | 1 selects mclk = 384·fs, 0 selects mclk = 256·fs |
| prescale | input | PSC_W | Master-clock half period in system clocks |
| inValid | input | 1 | A sample pair is offered |
| inLeft | input | 16 | Left-channel sample |
| inRight | input | 16 | Right-channel sample |
| inReady | output | 1 | The buffer can accept a pair |
| dataReq | output | 1 | Request for more data |
| underrun | output | 1 | Sticky flag: a frame started with an empty buffer |
| mclk | output | 1 | Codec master clock |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: low for left, high for right |
| sd | output | 1 | Serial data |

## Verification
The frame-start edge does two jobs at once: it latches new framing settings and it loads the next sample pair, and both must land on the same frame. The bench provokes this by switching from I2S 16-bit to left-justified 8-bit partway through a frame while pairs are streaming. A scoreboard records the settings present at each word-select fall and rebuilds every frame's 32 bits from them. The frame running when the switch happens must still use the old layout, and the next one must use the new layout with the next pair. A second overlap occurs when the transmit-idle control is released: the first frame start after release must take a pair. The bench checks this through the frame contents.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SLOT_W   = 5;

  typedef struct packed {
    logic              loadFrame;
    logic              leftJust;
    logic              width8;
    logic [SLOT_W-1:0] slot;
  } txStrobe_t;
endpackage

// File: rtl/i2s_tx_timing.sv
module i2s_tx_timing
  import i2s_tx_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             leftJust,
  input  logic             width8,
  input  logic             ratio384,
  input  logic [PSC_W-1:0] prescale,
  output txStrobe_t        strb,
  output logic             mclk,
  output logic             bclk,
  output logic             ws
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;
  localparam logic [SLOT_W-1:0] MID_SLOT  = SLOT_W'(SAMPLE_W - 1);

  logic             shLj, shW8, sh384;
  logic [PSC_W-1:0] shPsc, divCnt, pscLast;
  logic [3:0]       halfCnt, halfLast;
  logic [SLOT_W-1:0] slot;
  logic             mTick, bTog, bFall, frameStart;

  assign pscLast    = (shPsc == '0) ? '0 : shPsc - 1'b1;
  assign halfLast   = sh384 ? 4'd11 : 4'd7;
  assign mTick      = (divCnt == pscLast);
  assign bTog       = mTick && (halfCnt == halfLast);
  assign bFall      = bTog && bclk;
  assign frameStart = bFall && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      divCnt  <= '0;
      halfCnt <= '0;
      slot    <= LAST_SLOT;
      mclk    <= 1'b0;
      bclk    <= 1'b0;
      ws      <= 1'b1;
      if (!rstN) begin
        shLj <= 1'b0; shW8 <= 1'b0; sh384 <= 1'b0; shPsc <= '0;
      end else begin
        shLj <= leftJust; shW8 <= width8; sh384 <= ratio384; shPsc <= prescale;
      end
    end else begin
      divCnt <= mTick ? '0 : divCnt + 1'b1;
      if (mTick) begin
        mclk    <= ~mclk;
        halfCnt <= (halfCnt == halfLast) ? '0 : halfCnt + 1'b1;
      end
      if (bTog) bclk <= ~bclk;
      if (bFall) begin
        slot <= slot + 1'b1;
        if (slot == MID_SLOT)       ws <= 1'b1;
        else if (slot == LAST_SLOT) ws <= 1'b0;
      end
      if (frameStart) begin
        shLj <= leftJust; shW8 <= width8; sh384 <= ratio384; shPsc <= prescale;
      end
    end
  end

  assign strb.loadFrame = frameStart;
  assign strb.leftJust  = shLj;
  assign strb.width8    = shW8;
  assign strb.slot      = slot;

  // R4
  ws_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && (ws != $past(ws))) |-> ($past(bclk) && !bclk));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(frameStart)) |-> $stable({shLj, shW8, sh384, shPsc}));

  // R3
  ws_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $fell(ws)) |-> $past(frameStart));
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                txIdle,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                inReady,
  output logic                dataReq,
  input  txStrobe_t           strb,
  output logic                sd,
  output logic                underrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [3:0] TOP_BIT = 4'(SAMPLE_W - 1);
  localparam logic [3:0] HALF_W  = 4'(SAMPLE_W / 2);

  logic [SAMPLE_W-1:0] memL [DEPTH];
  logic [SAMPLE_W-1:0] memR [DEPTH];
  logic [AW-1:0]       wrPtr, rdPtr;
  logic [CW-1:0]       count;
  logic [SAMPLE_W-1:0] curL, curR, prevR;
  logic                active, push, pop;
  logic [SLOT_W-1:0]   pos;
  logic [3:0]          idx;

  assign active  = enable && !txIdle;
  assign inReady = (count < CW'(DEPTH));
  assign dataReq = active && inReady;
  assign push    = inValid && inReady;
  assign pop     = strb.loadFrame && active && (count != '0);

  always_ff @(posedge clk) begin
    if (push) begin
      memL[wrPtr] <= inLeft;
      memR[wrPtr] <= inRight;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      curL     <= '0;
      curR     <= '0;
      prevR    <= '0;
      underrun <= 1'b0;
    end else if (strb.loadFrame) begin
      prevR <= curR;
      if (pop) begin
        curL <= memL[rdPtr];
        curR <= memR[rdPtr];
      end else begin
        curL <= '0;
        curR <= '0;
      end
      if (active && (count == '0)) underrun <= 1'b1;
    end
  end

  always_comb begin
    pos = strb.leftJust ? strb.slot : strb.slot - 1'b1;
    idx = pos[3:0];
    sd  = 1'b0;
    if (!strb.leftJust && (strb.slot == '0))
      sd = strb.width8 ? 1'b0 : prevR[0];
    else if (!strb.width8 || (idx < HALF_W))
      sd = pos[4] ? curR[TOP_BIT - idx] : curL[TOP_BIT - idx];
  end

  // R8
  pop_at_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count < $past(count)) |-> $past(strb.loadFrame));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && enable) |=> underrun);

  // R10
  idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txIdle) |=> (count >= $past(count)));
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             txIdle,
  input  logic             leftJust,
  input  logic             width8,
  input  logic             ratio384,
  input  logic [PSC_W-1:0] prescale,
  input  logic             inValid,
  input  logic [15:0]      inLeft,
  input  logic [15:0]      inRight,
  output logic             inReady,
  output logic             dataReq,
  output logic             underrun,
  output logic             mclk,
  output logic             bclk,
  output logic             ws,
  output logic             sd
);
  txStrobe_t strb;

  i2s_tx_timing #(.PSC_W(PSC_W)) u_timing (
    .clk(clk), .rstN(rstN), .enable(enable),
    .leftJust(leftJust), .width8(width8), .ratio384(ratio384), .prescale(prescale),
    .strb(strb), .mclk(mclk), .bclk(bclk), .ws(ws)
  );

  i2s_tx_shifter #(.DEPTH(DEPTH)) u_shifter (
    .clk(clk), .rstN(rstN), .enable(enable), .txIdle(txIdle),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .inReady(inReady), .dataReq(dataReq),
    .strb(strb), .sd(sd), .underrun(underrun)
  );

  // R4
  sd_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && (sd != $past(sd))) |-> ($past(bclk) && !bclk));
endmodule

// File: tb/i2s_tx_tb.sv
module i2s_tx_tb;
  localparam int CLK_NS = 10;
  localparam int PSC_W  = 8;
  localparam int DEPTH  = 2;

  logic clk = 0, rstN = 0, enable = 0, cfgIdle = 0;
  logic cfgLj = 0, cfgW8 = 0, cfgR384 = 0;
  logic [PSC_W-1:0] cfgPsc = 1;
  logic inValid = 0;
  logic [15:0] inLeft = 0, inRight = 0;
  logic inReady, dataReq, underrun, mclk, bclk, ws, sd;

  int checks = 0, fails = 0;
  logic [31:0] expQ [$];
  logic snapLj = 0, snapW8 = 0, snapIdle = 0;
  logic [15:0] lastR = 0;
  logic lastLj = 0;
  bit haveFrame = 0;

  always #(CLK_NS/2) clk = ~clk;

  i2s_tx #(.PSC_W(PSC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .txIdle(cfgIdle),
    .leftJust(cfgLj), .width8(cfgW8), .ratio384(cfgR384), .prescale(cfgPsc),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .inReady(inReady), .dataReq(dataReq), .underrun(underrun),
    .mclk(mclk), .bclk(bclk), .ws(ws), .sd(sd)
  );

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return {16'(k * 15133 + 32769), 16'(k * 21159 + 3855)};
  endfunction

  // driver: pushes a pair and records it in the scoreboard on acceptance
  task automatic push(input logic [31:0] pair);
    @(negedge clk);
    inValid = 1; {inLeft, inRight} = pair;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    expQ.push_back(pair);
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic feed(input int n, input int base);
    for (int i = 0; i < n; i++) push(pat(base + i));
  endtask

  // rebuild a frame from the settings seen at its start
  task automatic judge(input logic [31:0] got, input logic [31:0] gotWs,
                       input logic lj, input logic w8, input logic idle);
    logic [15:0] L = '0, R = '0;
    logic [31:0] exp = '0;
    logic [4:0] pos;
    logic [3:0] idx;
    string tag;
    bit zero;
    zero = idle || (expQ.size() == 0);
    if (!zero) {L, R} = expQ.pop_front();
    for (int s = 0; s < 32; s++) begin
      logic b;
      pos = lj ? 5'(s) : 5'(s - 1);
      idx = pos[3:0];
      if (!lj && s == 0)       b = w8 ? 1'b0 : lastR[0];
      else if (w8 && idx >= 8) b = 1'b0;
      else                     b = pos[4] ? R[15 - idx] : L[15 - idx];
      exp[31 - s] = b;
    end
    if (idle)              tag = "R10";
    else if (zero)         tag = "R9";
    else if (lj != lastLj) tag = "R11";
    else if (lj)           tag = "R6";
    else if (w8)           tag = "R7";
    else                   tag = "R5";
    check(tag, "frame bits", 64'(got), 64'(exp));
    check("R4", "word select pattern", 64'(gotWs), 64'h0000FFFF);
    lastR  = R;
    lastLj = lj;
  endtask

  initial forever @(negedge ws) begin
    snapLj = cfgLj; snapW8 = cfgW8; snapIdle = cfgIdle;
  end

  initial forever @(negedge enable) haveFrame = 0;

  // monitor: collects 32 slots per frame at bclk rising edges
  initial begin
    logic [31:0] bits = 0, wsBits = 0;
    int nb = 0;
    logic prevWs = 1;
    logic fLj = 0, fW8 = 0, fIdle = 0;
    forever begin
      @(posedge bclk);
      if (!ws && prevWs) begin
        if (haveFrame && nb == 32) judge(bits, wsBits, fLj, fW8, fIdle);
        haveFrame = 1; nb = 0;
        fLj = snapLj; fW8 = snapW8; fIdle = snapIdle;
      end
      prevWs = ws;
      bits   = {bits[30:0], sd};
      wsBits = {wsBits[30:0], ws};
      nb++;
    end
  end

  task automatic measMclk(input int expClk, input string tag);
    longint t0;
    @(posedge mclk); t0 = $time;
    @(posedge mclk);
    check(tag, "mclk period", 64'(($time - t0) / CLK_NS), 64'(expClk));
  endtask

  task automatic measFrame(input int expClk, input string tag);
    longint t0;
    @(negedge ws); t0 = $time;
    @(negedge ws);
    check(tag, "frame period", 64'(($time - t0) / CLK_NS), 64'(expClk));
  endtask

  task automatic drainAndStop;
    wait (underrun == 1'b1);
    repeat (2) @(negedge ws);
    @(negedge clk);
    check("R9", "underrun sticky", 64'(underrun), 64'd1);
    enable = 0;
    repeat (2) @(negedge clk);
    check("R9", "underrun cleared by disable", 64'(underrun), 64'd0);
    check("R1", "ws idle high", 64'(ws), 64'd1);
    check("R1", "bclk idle low", 64'(bclk), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "ws in reset", 64'(ws), 64'd1);
    check("R1", "bclk/mclk/sd in reset", 64'({bclk, mclk, sd}), 64'd0);
    check("R1", "underrun in reset", 64'(underrun), 64'd0);
    rstN = 1;
    repeat (40) @(negedge clk);
    check("R1", "clocks stopped while disabled", 64'({bclk, mclk}), 64'd0);
    check("R1", "no request while disabled", 64'(dataReq), 64'd0);
    check("R8", "ready when empty", 64'(inReady), 64'd1);

    // Phase A: I2S 16-bit, P=1, 256fs, then mid-frame switch to LJ 8-bit
    push(pat(0)); push(pat(1));
    check("R8", "full buffer not ready", 64'(inReady), 64'd0);
    @(negedge clk) enable = 1;
    fork
      feed(10, 2);
      begin
        measMclk(2, "R2");
        measFrame(512, "R3");
        @(negedge ws);
        repeat (37) @(negedge clk);
        cfgLj = 1; cfgW8 = 1;
      end
    join
    drainAndStop();

    // Phase B: I2S 8-bit, P=3, 384fs
    cfgLj = 0; cfgW8 = 1; cfgR384 = 1; cfgPsc = 3;
    push(pat(20)); push(pat(21));
    @(negedge clk) enable = 1;
    fork
      feed(4, 22);
      begin
        measMclk(6, "R2");
        measFrame(2304, "R3");
      end
    join
    drainAndStop();

    // Phase C: left-justified 16-bit, prescale 0, transmit idle first
    cfgLj = 1; cfgW8 = 0; cfgR384 = 0; cfgPsc = 0; cfgIdle = 1;
    push(pat(40)); push(pat(41));
    @(negedge clk) enable = 1;
    measMclk(2, "R2");
    measFrame(512, "R10");
    repeat (2) @(negedge ws);
    @(negedge clk);
    check("R10", "no underrun while idle", 64'(underrun), 64'd0);
    check("R10", "no pair taken while idle", 64'(inReady), 64'd0);
    check("R10", "no request while idle", 64'(dataReq), 64'd0);
    cfgIdle = 0;
    wait (underrun == 1'b1);
    @(negedge clk);
    check("R8", "request when active and empty", 64'(dataReq), 64'd1);
    repeat (2) @(negedge ws);
    @(negedge clk);
    check("R8", "all pairs consumed", 64'(expQ.size()), 64'd0);
    finishRun();
  end
endmodule